// File: doc/BRIEF.md
# Processor Sleep Clock Gate

This block gives the processor a sleep mode. It does not touch the free-running master clock. Instead it produces a registered enable that a clock-gating cell, or the core's clock-enable input, uses to stop the processor clock. The enable only changes on a master-clock edge. Other bus masters keep running on the master clock while the processor sleeps.

The core sends a one-cycle pulse when it executes a wait-for-interrupt or wait-for-event instruction. It also supplies an instruction-complete signal. A low-power-mode control bit chooses between this sleep mode and deeper modes that are handled elsewhere. When the bit is 0, a wait request moves the gate into a pending-stop state. The clock is cut once the core reports that the current instruction has finished. Two interrupt classes, fast and normal, each have a request vector and an enable mask. Any request whose enable bit is set brings the clock back one cycle after it is seen. A reset always leaves the clock running.

Top module: `cpu_sleep_gate`

## Requirements
- R1: After reset `cpu_clk_en` is 1 and `sleeping` is 0.
- R2: A `wait_req` pulse while running, with `lpm_sel` = 0, no enabled interrupt pending and `insn_done` = 1 in the same cycle, drives `cpu_clk_en` to 0 in the following cycle.
- R3: A `wait_req` pulse while `lpm_sel` = 1 is ignored: `cpu_clk_en` stays 1 and `sleeping` stays 0.
- R4: An accepted request with `insn_done` = 0 keeps `cpu_clk_en` at 1. The clock stops in the cycle after the first cycle in which `insn_done` is 1.
- R5: While sleeping, a fast request bit `fast_irq[i]` with `fast_en[i]` = 1 sets `cpu_clk_en` to 1 in the following cycle.
- R6: While sleeping, a normal request bit `norm_irq[i]` with `norm_en[i]` = 1 sets `cpu_clk_en` to 1 in the following cycle.
- R7: Requests whose enable bit is 0 never wake the processor: `cpu_clk_en` stays 0.
- R8: If an enabled interrupt is pending in the cycle the wait request arrives, the request is dropped and the clock keeps running.
- R9: An enabled interrupt that arrives while the stop is pending cancels the stop, so the clock never turns off.
- R10: Asserting `rst` while sleeping sets `cpu_clk_en` to 1 on the next edge.
- R11: `sleeping` is always the inverse of `cpu_clk_en`. `wait_req` pulses during a pending stop or during sleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | One-cycle pulse on a wait-for-interrupt or wait-for-event instruction |
| insn_done | input | 1 | Core reports that the instruction in progress has finished |
| lpm_sel | input | 1 | Low-power-mode select; a request is honoured only when 0 |
| fast_irq | input | FAST_W | Fast interrupt requests |
| fast_en | input | FAST_W | Enable mask for the fast requests |
| norm_irq | input | NORM_W | Normal interrupt requests |
| norm_en | input | NORM_W | Enable mask for the normal requests |
| cpu_clk_en | output | 1 | Registered processor clock enable |
| sleeping | output | 1 | Registered sleep status flag |

## Verification
The bench looks for races between a wait request and interrupts. One case is a request that arrives with an enabled interrupt already pending: a design that ignores this would sleep and miss the wake-up. Another is an interrupt that arrives while the stop is still pending: a design that ignores this would turn the clock off anyway. The bench holds `insn_done` low for several cycles to catch a gate that stops the clock too early, which would cut off an instruction partway through. It raises requests whose enable bit is 0 to catch an inverted or missing mask, and it sends wait pulses during pending and sleep states to catch a design that restarts its stop sequence.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PEND  = 2'd1,
    ST_SLEEP = 2'd2
  } gate_state_t;
endpackage

// File: rtl/sleep_wake_detect.sv
module sleep_wake_detect #(
  parameter int FAST_W = 4,
  parameter int NORM_W = 16
) (
  input  logic [FAST_W-1:0] fast_irq,
  input  logic [FAST_W-1:0] fast_en,
  input  logic [NORM_W-1:0] norm_irq,
  input  logic [NORM_W-1:0] norm_en,
  output logic              wake
);
  logic [FAST_W-1:0] fast_hit;
  logic [NORM_W-1:0] norm_hit;

  // Per-line qualification of each request by its enable bit
  for (genvar i = 0; i < FAST_W; i++) begin : g_fast
    assign fast_hit[i] = fast_irq[i] & fast_en[i];
  end
  for (genvar j = 0; j < NORM_W; j++) begin : g_norm
    assign norm_hit[j] = norm_irq[j] & norm_en[j];
  end

  assign wake = (|fast_hit) | (|norm_hit);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wait_req,
  input  logic        insn_done,
  input  logic        lpm_sel,
  input  logic        wake,
  output gate_state_t state_q,
  output gate_state_t state_d
);
  logic accept;

  // A request counts only in RUN, with lpm_sel clear and no enabled interrupt pending
  assign accept = wait_req & ~lpm_sel & ~wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (accept) state_d = insn_done ? ST_SLEEP : ST_PEND;
      end
      ST_PEND: begin
        if (wake)           state_d = ST_RUN;
        else if (insn_done) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  AST_LPM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && wait_req && lpm_sel) |=> (state_q == ST_RUN)); // R3
  AST_WAIT_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && !insn_done && !wake) |=> (state_q == ST_PEND)); // R4
  AST_PENDING_IRQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && wake) |=> (state_q == ST_RUN)); // R8
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && wake) |=> (state_q == ST_RUN)); // R9
endmodule

// File: rtl/sleep_out_reg.sv
module sleep_out_reg
  import sleep_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  gate_state_t state_d,
  output logic        cpu_clk_en,
  output logic        sleeping
);
  // Both outputs come straight from flops, so they only change on a master-clock edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      sleeping   <= 1'b0;
    end else begin
      cpu_clk_en <= (state_d != ST_SLEEP);
      sleeping   <= (state_d == ST_SLEEP);
    end
  end
endmodule

// File: rtl/cpu_sleep_gate.sv
module cpu_sleep_gate
  import sleep_gate_pkg::*;
#(
  parameter int FAST_W = 4,
  parameter int NORM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_req,
  input  logic              insn_done,
  input  logic              lpm_sel,
  input  logic [FAST_W-1:0] fast_irq,
  input  logic [FAST_W-1:0] fast_en,
  input  logic [NORM_W-1:0] norm_irq,
  input  logic [NORM_W-1:0] norm_en,
  output logic              cpu_clk_en,
  output logic              sleeping
);
  logic        wake;
  gate_state_t state_q;
  gate_state_t state_d;

  sleep_wake_detect #(.FAST_W(FAST_W), .NORM_W(NORM_W)) u_wake (
    .fast_irq (fast_irq),
    .fast_en  (fast_en),
    .norm_irq (norm_irq),
    .norm_en  (norm_en),
    .wake     (wake)
  );

  sleep_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wait_req  (wait_req),
    .insn_done (insn_done),
    .lpm_sel   (lpm_sel),
    .wake      (wake),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  sleep_out_reg u_out (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .cpu_clk_en (cpu_clk_en),
    .sleeping   (sleeping)
  );

  AST_FLAG_INVERSE: assert property (@(posedge clk) disable iff (rst)
    sleeping == !cpu_clk_en); // R11
  AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (sleeping && wake) |=> cpu_clk_en); // R5
  AST_MASKED_STAYS: assert property (@(posedge clk) disable iff (rst)
    (sleeping && !wake && !wait_req) |=> !cpu_clk_en); // R7
  AST_STOP_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && insn_done && !wake) |=> !cpu_clk_en); // R2
endmodule

// File: tb/sim_cpu_sleep_gate.sv
module sim_cpu_sleep_gate;
  localparam int FW = 4;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_req = 1'b0, insn_done = 1'b0, lpm_sel = 1'b0;
  logic [FW-1:0] fast_irq = '0, fast_en = '0;
  logic [NW-1:0] norm_irq = '0, norm_en = '0;
  logic cpu_clk_en, sleeping;

  int n_chk = 0;
  int n_bad = 0;
  int mst = 0;   // bench model: 0 run, 1 pending stop, 2 sleep

  always #5 clk = ~clk;

  cpu_sleep_gate #(.FAST_W(FW), .NORM_W(NW)) u0 (
    .clk(clk), .rst(rst), .wait_req(wait_req), .insn_done(insn_done),
    .lpm_sel(lpm_sel), .fast_irq(fast_irq), .fast_en(fast_en),
    .norm_irq(norm_irq), .norm_en(norm_en),
    .cpu_clk_en(cpu_clk_en), .sleeping(sleeping));

  function automatic int model_next(int s, logic wr, logic lpm, logic done, logic wk);
    case (s)
      0: return (wr && !lpm && !wk) ? (done ? 2 : 1) : 0;
      1: return wk ? 0 : (done ? 2 : 1);
      default: return wk ? 0 : 2;
    endcase
  endfunction

  function automatic logic wake_now();
    return (|(fast_irq & fast_en)) | (|(norm_irq & norm_en));
  endfunction

  task automatic check(string req, logic exp_en);
    n_chk++;
    if (cpu_clk_en !== exp_en || sleeping !== !exp_en) begin
      n_bad++;
      $display("FAIL %s: clk_en/sleeping = %b/%b, expected %b/%b",
               req, cpu_clk_en, sleeping, exp_en, !exp_en);
    end
  endtask

  // Apply inputs after the falling edge, update the model, then wait one full cycle
  task automatic step(logic wr, logic done);
    @(negedge clk);
    wait_req = wr; insn_done = done;
    mst = rst ? 0 : model_next(mst, wr, lpm_sel, done, wake_now());
    @(negedge clk);
    wait_req = 1'b0; insn_done = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mst = 0;
    check("R1 reset state", 1'b1);

    // R3: lpm_sel set, request ignored
    lpm_sel = 1'b1; step(1'b1, 1'b1); check("R3 lpm blocks", 1'b1);
    lpm_sel = 1'b0;

    // R8: enabled interrupt pending at request
    norm_irq = 16'h0010; norm_en = 16'h0010;
    step(1'b1, 1'b1); check("R8 pending irq keeps run", 1'b1);
    norm_irq = '0; norm_en = '0;

    // R4 then R2: hold insn_done low for a while
    step(1'b1, 1'b0); check("R4 wait for done", 1'b1);
    idle(3); check("R4 still waiting", 1'b1);
    step(1'b0, 1'b1); check("R2 stop after done", 1'b0);

    // R7: masked requests do not wake; R11: wait pulse in sleep ignored
    fast_irq = 4'hF; norm_irq = 16'hFFFF; fast_en = 4'h0; norm_en = 16'h0000;
    idle(2); check("R7 masked irq", 1'b0);
    fast_irq = '0; norm_irq = '0;
    step(1'b1, 1'b1); check("R11 wait in sleep", 1'b0);

    // R5: fast wake
    fast_en = 4'b0100; fast_irq = 4'b0100;
    step(1'b0, 1'b0); check("R5 fast wake", 1'b1);
    fast_irq = '0; fast_en = '0;

    // R2 direct, then R6 normal wake
    step(1'b1, 1'b1); check("R2 immediate stop", 1'b0);
    norm_en = 16'h8000; norm_irq = 16'h8000;
    step(1'b0, 1'b0); check("R6 normal wake", 1'b1);
    norm_irq = '0; norm_en = '0;

    // R9: interrupt during pending stop
    step(1'b1, 1'b0); check("R9 pending", 1'b1);
    fast_en = 4'b0001; fast_irq = 4'b0001;
    step(1'b0, 1'b1); check("R9 abort stop", 1'b1);
    fast_irq = '0; fast_en = '0;
    step(1'b0, 1'b1); check("R9 stays running", 1'b1);

    // R10: reset from sleep
    step(1'b1, 1'b1); check("R10 asleep", 1'b0);
    rst = 1'b1; step(1'b0, 1'b0); check("R10 reset wakes", 1'b1);
    rst = 1'b0; mst = 0;

    // Random phase: checked against the bench model each cycle
    for (int k = 0; k < 3000; k++) begin
      logic wr, dn;
      int prev;
      prev = mst;
      lpm_sel = ($urandom % 8) == 0;
      fast_en = 4'($urandom);
      norm_en = 16'($urandom);
      fast_irq = (($urandom % 10) == 0) ? 4'($urandom) : 4'h0;
      norm_irq = (($urandom % 10) == 0) ? 16'($urandom) : 16'h0;
      wr = ($urandom % 4) == 0;
      dn = ($urandom % 3) == 0;
      step(wr, dn);
      case (prev)
        0: check("R11 random from run", mst != 2);
        1: check("R11 random from pending", mst != 2);
        default: check("R11 random from sleep", mst != 2);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule